// File: doc/BRIEF.md
# Quadword DMA Read Channel

This block is one DMA channel. Software programs it through a small register port with three values: a memory start address, a transfer length counted in 128-bit quadwords, and a start command. After the start command the channel reads the quadwords one at a time from a memory read port. It moves each returned quadword onto a valid/ready output stream and marks the final beat with a last flag. When the final beat has been accepted, the channel goes back to idle and raises a done pulse for one clock.

The channel keeps at most one read outstanding. A fetched quadword stays in a single holding register until the stream sink takes it. No new read is issued while that register is full. A transfer of zero quadwords finishes at once. While a transfer is running, the register port ignores all writes. Software can poll the channel's busy state through the control register.

Top module: `qdma_channel`

## Requirements
- R1: The start address is written and read back at register offset 0x10. The quadword count is written and read back at offset 0x20.
- R2: A write of 1 in bit 0 of the control register (offset 0x00) while the channel is idle starts a transfer. Reading offset 0x00 returns the busy flag in bit 0. That flag is 1 from the clock after the start until completion, and 0 otherwise.
- R3: A transfer of N quadwords issues exactly N memory reads. The first read goes to the programmed start address, and each later read goes to an address 16 higher than the one before.
- R4: The stream carries the returned quadwords in read order. While out_valid is high and out_ready is low, out_valid, out_data and out_last stay unchanged.
- R5: out_last is high only on the beat that carries the final quadword of the programmed count.
- R6: No memory read is issued while a quadword is waiting on the stream (out_valid high).
- R7: Each started transfer produces exactly one done_pulse, one cycle wide. That pulse occurs in the cycle where busy reads back as 0 again.
- R8: A start with a count of zero raises done_pulse in the next cycle. It issues no memory read and no stream beat.
- R9: While busy, writes to any register offset, including a second start command, have no effect.
- R10: After reset, mem_rd_en, out_valid, out_last and done_pulse are 0, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register offset for the write and for the read-back |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_data | output | 32 | Read-back value of the register at cfg_addr (combinational) |
| mem_rd_en | output | 1 | Memory read request, one cycle per quadword |
| mem_rd_addr | output | 32 | Byte address of the quadword requested |
| mem_rd_data | input | 128 | Returned quadword |
| mem_rd_valid | input | 1 | mem_rd_data is valid this cycle |
| out_valid | output | 1 | Stream beat available |
| out_data | output | 128 | Stream quadword |
| out_last | output | 1 | Beat carries the final quadword |
| out_ready | input | 1 | Sink accepts the beat |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports arise when a slow memory and a stalling sink overlap: a quadword sits in the holding register for many cycles while the read port must stay silent. The bench gets there by sweeping every count from zero to six. Each count runs against three memory latencies and three sink patterns: always ready, alternating, and pseudo-random. The other hard case is a register write that arrives in the middle of a transfer. To reach it, the bench writes a new address, a new count and a second start while a long, stalled transfer is still running. It then reads the registers back and counts the beats and done pulses that follow.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_e;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_ADDR  = 8'h10;
    localparam logic [7:0] OFS_COUNT = 8'h20;

    localparam int QW_BYTES = 16;

endpackage

// File: rtl/qdma_regs.sv
module qdma_regs #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int CFG_AW = 8,
    parameter int CFG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] wr_data,
    input  logic              busy,
    output logic [CFG_DW-1:0] rd_data,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  qw_count,
    output logic              start
);
    import qdma_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  wr_ok;

    always_comb begin
        regs_d = regs_q;
        wr_ok  = wr_en && !busy;
        start  = 1'b0;
        if (wr_ok) begin
            if (cfg_addr == CFG_AW'(OFS_ADDR)) begin
                regs_d.addr = ADDR_W'(wr_data);
            end
            if (cfg_addr == CFG_AW'(OFS_COUNT)) begin
                regs_d.count = CNT_W'(wr_data);
            end
            if (cfg_addr == CFG_AW'(OFS_CTRL)) begin
                start = wr_data[0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (cfg_addr == CFG_AW'(OFS_CTRL)) begin
            rd_data[0] = busy;
        end else if (cfg_addr == CFG_AW'(OFS_ADDR)) begin
            rd_data = CFG_DW'(regs_q.addr);
        end else if (cfg_addr == CFG_AW'(OFS_COUNT)) begin
            rd_data = CFG_DW'(regs_q.count);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign base_addr = regs_q.addr;
    assign qw_count  = regs_q.count;

endmodule

// File: rtl/qdma_seq.sv
module qdma_seq #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  qw_count,
    input  logic              mem_rd_valid,
    input  logic              take,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              capture,
    output logic              capture_last,
    output logic              busy,
    output logic              done
);
    import qdma_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(QW_BYTES);
    localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  remain;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (qw_count == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.addr   = base_addr;
                        seq_d.remain = qw_count;
                        seq_d.state  = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                seq_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rd_valid) begin
                    seq_d.state = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (take) begin
                    if (seq_q.remain == ONE) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.remain = seq_q.remain - ONE;
                        seq_d.addr   = seq_q.addr + STEP;
                        seq_d.state  = ST_REQ;
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, addr: '0, remain: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_rd_en    = (seq_q.state == ST_REQ);
    assign mem_rd_addr  = seq_q.addr;
    assign capture      = (seq_q.state == ST_WAIT) && mem_rd_valid;
    assign capture_last = (seq_q.remain == ONE);
    assign busy         = (seq_q.state != ST_IDLE);
    assign done         = seq_q.done;

endmodule

// File: rtl/qdma_hold.sv
module qdma_hold #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_last,
    input  logic [DATA_W-1:0] load_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data,
    output logic              take
);
    typedef struct packed {
        logic              valid;
        logic              last;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        take   = hold_q.valid && out_ready;
        if (load) begin
            hold_d.valid = 1'b1;
            hold_d.last  = load_last;
            hold_d.data  = load_data;
        end else if (take) begin
            hold_d.valid = 1'b0;
            hold_d.last  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign out_valid = hold_q.valid;
    assign out_last  = hold_q.last;
    assign out_data  = hold_q.data;

endmodule

// File: rtl/qdma_channel.sv
module qdma_channel #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 128,
    parameter int CFG_AW = 8,
    parameter int CFG_DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wr_data,
    output logic [CFG_DW-1:0] cfg_rd_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              mem_rd_valid,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready,
    output logic              done_pulse
);
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  qw_count;
    logic              start;
    logic              busy;
    logic              capture;
    logic              capture_last;
    logic              take;

    qdma_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .wr_data(cfg_wr_data),
        .busy(busy), .rd_data(cfg_rd_data),
        .base_addr(base_addr), .qw_count(qw_count), .start(start)
    );

    qdma_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .start(start), .base_addr(base_addr), .qw_count(qw_count),
        .mem_rd_valid(mem_rd_valid), .take(take),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .capture(capture), .capture_last(capture_last),
        .busy(busy), .done(done_pulse)
    );

    qdma_hold #(
        .DATA_W(DATA_W)
    ) hold_i (
        .clk(clk), .rst_n(rst_n),
        .load(capture), .load_last(capture_last), .load_data(mem_rd_data),
        .out_ready(out_ready),
        .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
        .take(take)
    );

endmodule

// File: rtl/qdma_channel_chk.sv
module qdma_channel_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              start,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CNT_W-1:0]  reg_count,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_last,
    input logic [DATA_W-1:0] out_data,
    input logic              done_pulse
);
    logic [ADDR_W-1:0] exp_addr;

    // Expected read address, tracked independently of the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_addr <= '0;
        end else if (start && !busy) begin
            exp_addr <= reg_addr;
        end else if (mem_rd_en) begin
            exp_addr <= exp_addr + ADDR_W'(16);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && mem_rd_en) begin
            assert_addr_seq_R3: assert (mem_rd_addr == exp_addr)
                else $error("read address out of sequence");
        end
    end

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    assert_last_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_no_read_while_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_rd_en);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !busy);

    assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && reg_count == '0 |=> done_pulse && !busy && !mem_rd_en);

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(reg_addr) && $stable(reg_count));

endmodule

bind qdma_channel qdma_channel_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .busy(busy), .start(start),
    .reg_addr(base_addr), .reg_count(qw_count),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .out_data(out_data),
    .done_pulse(done_pulse)
);

// File: tb/qdma_channel_tb_top.sv
`timescale 1ns/1ps
module qdma_channel_tb_top;

    logic         clk;
    logic         rst_n;
    logic         cfg_wr_en;
    logic [7:0]   cfg_addr;
    logic [31:0]  cfg_wr_data;
    logic [31:0]  cfg_rd_data;
    logic         mem_rd_en;
    logic [31:0]  mem_rd_addr;
    logic [127:0] mem_rd_data;
    logic         mem_rd_valid;
    logic         out_valid;
    logic [127:0] out_data;
    logic         out_last;
    logic         out_ready;
    logic         done_pulse;

    int checks = 0;
    int fails  = 0;

    // per-transfer bookkeeping
    logic [31:0] cur_base;
    int          cur_count;
    int          reads_seen;
    int          beats;
    int          dones;
    int          lat;
    int          rmode;
    logic [7:0]  lfsr;
    bit          prev_done;

    // memory model state
    bit          pend;
    int          wait_n;
    logic [31:0] pend_addr;

    qdma_channel dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .done_pulse(done_pulse)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [127:0] mem_word(input logic [31:0] a);
        return {a ^ 32'hA5A5_0000, ~a, a + 32'h0000_1234, a};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory responder, sink and stream monitor, all at the falling edge
    initial begin
        mem_rd_valid = 1'b0;
        mem_rd_data  = '0;
        out_ready    = 1'b0;
        pend         = 1'b0;
        wait_n       = 0;
        pend_addr    = '0;
        lfsr         = 8'h5B;
        prev_done    = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                mem_rd_valid = 1'b0;
                if (pend) begin
                    if (wait_n == 0) begin
                        mem_rd_valid = 1'b1;
                        mem_rd_data  = mem_word(pend_addr);
                        pend         = 1'b0;
                    end else begin
                        wait_n--;
                    end
                end
                if (mem_rd_en) begin
                    // R3: address sequence, R6: silent while a beat waits
                    check(mem_rd_addr == cur_base + 32'(16 * reads_seen), "R3 read address",
                          128'(mem_rd_addr), 128'(cur_base + 32'(16 * reads_seen)));
                    check(!out_valid, "R6 read while held", 128'(out_valid), 128'd0);
                    pend      = 1'b1;
                    pend_addr = mem_rd_addr;
                    wait_n    = lat - 1;
                    reads_seen++;
                end
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                case (rmode)
                    0:       out_ready = 1'b1;
                    1:       out_ready = ~out_ready;
                    default: out_ready = lfsr[0];
                endcase
                if (out_valid && out_ready) begin
                    check(out_data == mem_word(cur_base + 32'(16 * beats)), "R4 beat data",
                          out_data, mem_word(cur_base + 32'(16 * beats)));
                    check(out_last == (beats == cur_count - 1), "R5 last flag",
                          128'(out_last), 128'(beats == cur_count - 1));
                    beats++;
                end
                if (done_pulse) begin
                    dones++;
                    if (prev_done) check(1'b0, "R7 pulse width", 128'd2, 128'd1);
                end
                prev_done = done_pulse;
            end
        end
    end

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_addr    = a;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        cfg_wr_data = '0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rd_data;
    endtask

    task automatic begin_xfer(input logic [31:0] base, input int cnt,
                              input int l, input int m);
        logic [31:0] rd;
        cur_base   = base;
        cur_count  = cnt;
        reads_seen = 0;
        beats      = 0;
        dones      = 0;
        lat        = l;
        rmode      = m;
        cfg_write(8'h10, base);
        cfg_write(8'h20, 32'(cnt));
        cfg_write(8'h00, 32'h1);
        if (cnt == 0) begin
            // R8: pulse in the cycle right after the start edge
            check(done_pulse == 1'b1, "R8 zero count done", 128'(done_pulse), 128'd1);
        end else begin
            cfg_read(8'h00, rd);
            check(rd[0] == 1'b1, "R2 busy while running", 128'(rd), 128'd1);
        end
    endtask

    task automatic end_xfer();
        logic [31:0] rd;
        int spin;
        spin = 0;
        while (dones == 0 && spin < 3000) begin
            @(negedge clk);
            spin++;
        end
        repeat (4) @(negedge clk);
        check(reads_seen == cur_count, "R3 read count", 128'(reads_seen), 128'(cur_count));
        check(beats == cur_count, "R4 beat count", 128'(beats), 128'(cur_count));
        check(dones == 1, "R7 done count", 128'(dones), 128'd1);
        cfg_read(8'h00, rd);
        check(rd == 32'h0, "R2 idle after done", 128'(rd), 128'd0);
    endtask

    initial begin
        logic [31:0] rd;
        rst_n       = 1'b0;
        cfg_wr_en   = 1'b0;
        cfg_addr    = '0;
        cfg_wr_data = '0;
        cur_base    = '0;
        cur_count   = 0;
        reads_seen  = 0;
        beats       = 0;
        dones       = 0;
        lat         = 1;
        rmode       = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        check(!mem_rd_en && !out_valid && !out_last && !done_pulse, "R10 outputs after reset",
              128'({mem_rd_en, out_valid, out_last, done_pulse}), 128'd0);
        cfg_read(8'h00, rd);
        check(rd == 0, "R10 control reg", 128'(rd), 128'd0);
        cfg_read(8'h10, rd);
        check(rd == 0, "R10 address reg", 128'(rd), 128'd0);
        cfg_read(8'h20, rd);
        check(rd == 0, "R10 count reg", 128'(rd), 128'd0);

        // R1: register read-back
        cfg_write(8'h10, 32'h0001_2340);
        cfg_write(8'h20, 32'd3);
        cfg_read(8'h10, rd);
        check(rd == 32'h0001_2340, "R1 address reg", 128'(rd), 128'h12340);
        cfg_read(8'h20, rd);
        check(rd == 32'd3, "R1 count reg", 128'(rd), 128'd3);

        // Sweep counts, memory latencies and sink patterns (R2-R8)
        for (int c = 0; c <= 6; c++) begin
            for (int l = 1; l <= 3; l++) begin
                for (int m = 0; m < 3; m++) begin
                    begin_xfer(32'h0004_0000 + 32'(c * 32'h1000 + l * 32'h100 + m * 32'h30),
                               c, l, m);
                    end_xfer();
                end
            end
        end

        // R9: writes during a stalled, slow transfer are ignored
        begin_xfer(32'h0009_0000, 6, 3, 1);
        cfg_write(8'h10, 32'h000D_EAD0);
        cfg_write(8'h20, 32'd2);
        cfg_write(8'h00, 32'h1);
        cfg_read(8'h10, rd);
        check(rd == 32'h0009_0000, "R9 address unchanged", 128'(rd), 128'h90000);
        cfg_read(8'h20, rd);
        check(rd == 32'd6, "R9 count unchanged", 128'(rd), 128'd6);
        end_xfer();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule